// File: doc/BRIEF.md
# Two-Accumulator Pair Hash Checker

This block decides whether a candidate password hashes to a fixed pair of 16-bit values. A candidate arrives as a short burst of 16-bit words, one word per clock. Each word is mixed into two accumulators through byte swaps, an XOR and a modulo-2^16 addition. A word of all zeros rejects the candidate at once. A candidate is accepted when, after any update, both accumulators equal their target constants. A 40-bit candidate uses four clocks: a start cycle that clears the accumulators, then three data words. The fifth byte is carried in the third word with the other byte of that word zero. The verdict comes out a fixed two cycles after the last data word, so it overlaps the next candidate.

An upstream sequencer drives a start strobe, word-valid and last-word flags along with the word. Downstream logic sees a one-cycle result pulse with an accept bit. The two targets are parameters, so several checkers can run side by side with different constants.

Top module: `pair_hash_checker`

## Requirements
- R1: After reset, `res_vld_o` and `accept_o` are low. The accumulators hold zero and a candidate is open, so words that follow reset without a start strobe form a valid candidate.
- R2: A cycle with `start_i` high clears both accumulators and any verdict, and it opens a new candidate. The word in that cycle is ignored. A start cycle on its own produces no result. A start that arrives before the last word throws away the unfinished candidate, and no result is given for it.
- R3: For each accepted word W, with swap(x) exchanging bits [15:8] and [7:0] of x, the new A is B xor swap(W) and the new B is swap(A + swap(W)). Both are computed from the old values, and the sum drops its carry out of bit 15.
- R4: A valid word equal to 16'h0000 that arrives before any verdict rejects the candidate. A later word cannot undo that reject.
- R5: When the updated A equals TARGET_A and the updated B equals TARGET_B (defaults 16'hFEB1 and 16'h9298), the candidate is accepted. Later words, including a zero word, do not change that verdict.
- R6: Let the last word (`word_vld_i` and `last_i` high) be sampled at rising edge k. Then `res_vld_o` is high for exactly one cycle, the cycle that starts at edge k+2. `accept_o` carries the verdict in that cycle and is low whenever `res_vld_o` is low.
- R7: A cycle with neither `start_i` nor `word_vld_i` high leaves the accumulators and the verdict unchanged, so gaps between words do not alter the result.
- R8: After the last word of a candidate, further words are ignored and produce no result until the next start strobe.
- R9: Candidates may follow each other back to back, four cycles each. A result that appears while the next candidate is loading is not disturbed by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Clears the accumulators and opens a new candidate |
| word_vld_i | input | 1 | `word_i` holds a candidate word this cycle |
| last_i | input | 1 | Marks the current valid word as the candidate's last |
| word_i | input | 16 | Two candidate bytes; the first byte is in bits [15:8] |
| res_vld_o | output | 1 | One-cycle pulse per finished candidate |
| accept_o | output | 1 | Verdict: 1 means accepted; valid with `res_vld_o` |

## Verification
The bench uses a candidate whose match comes after the second word and is followed by a zero word. A checker that let later words override a verdict would wrongly report reject. Another candidate has a zero word followed by the word that would otherwise complete a match. A design that skipped zero words instead of rejecting them would accept it. A second instance, set to targets reached only when a carry out of bit 15 is dropped, catches an adder that keeps or folds in the carry.

Further cases cover other failure modes. A start strobe arriving mid-candidate, and a start strobe carrying a zero word, show whether discarded state leaks into the next result. Idle gaps show whether the design consumes words that are not marked valid. Words after the last one show whether a stray result pulse appears. Every result is checked against the exact edge it is due on, so a design with one pipeline stage too many or too few shows up as a missing pulse and an unexpected one.

// File: rtl/phc_pkg.sv
// Package: shared types for the pair hash checker.
// Assumes: nothing beyond IEEE 1800-2017.
package phc_pkg;

    // Verdict of one finished candidate as it moves toward the outputs.
    typedef struct packed {
        logic vld;   // a candidate finished in this slot
        logic acc;   // 1 = accepted, only meaningful with vld
    } verdict_t;

endpackage

// File: rtl/phc_mix.sv
// Module: phc_mix
// Purely combinational hash step. Given the current accumulators and one word,
// it returns the next accumulator values and flags a word of all zeros.
// Assumes: W is a multiple of 8; byte swap means full byte-order reversal,
// which for 16 bits exchanges the two bytes.
module phc_mix #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] w_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic         zero_o
);
    localparam int NB = W / 8;

    logic [W-1:0] w_sw;    // byte-reversed input word
    logic [W-1:0] sum;     // A + swap(W), modulo 2^W
    logic [W-1:0] sum_sw;  // byte-reversed sum

    // Byte reversal of the word and of the sum, one lane per byte.
    for (genvar i = 0; i < NB; i++) begin : g_swap
        assign w_sw[i*8 +: 8]   = w_i[(NB-1-i)*8 +: 8];
        assign sum_sw[i*8 +: 8] = sum[(NB-1-i)*8 +: 8];
    end

    // Cross-coupled update; the carry out of the top bit is dropped.
    assign sum    = a_i + w_sw;
    assign a_o    = b_i ^ w_sw;
    assign b_o    = sum_sw;
    assign zero_o = (w_i == '0);

endmodule

// File: rtl/phc_accum.sv
// Module: phc_accum
// Holds the two accumulators and the per-candidate state: whether the candidate
// is open, whether a verdict is latched, and what it is. Registers one verdict
// record when the last word of a candidate is taken.
// Assumes: start has priority over a word in the same cycle; words outside an
// open candidate are ignored; synchronous active-low reset acts like a start.
module phc_accum
    import phc_pkg::*;
#(
    parameter int           W        = 16,
    parameter logic [W-1:0] TARGET_A = 16'hFEB1,
    parameter logic [W-1:0] TARGET_B = 16'h9298
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         word_vld_i,
    input  logic         last_i,
    input  logic [W-1:0] word_i,
    output verdict_t     fin_o
);
    logic [W-1:0] acc_a_q, acc_b_q;
    logic         open_q, dec_q, ver_q;
    verdict_t     fin_q;

    logic [W-1:0] mix_a, mix_b;
    logic         mix_zero;
    logic         take;       // a word is consumed this cycle
    logic         nxt_dec, nxt_ver;
    logic [W-1:0] nxt_a, nxt_b;

    phc_mix #(.W(W)) u_mix (
        .a_i    (acc_a_q),
        .b_i    (acc_b_q),
        .w_i    (word_i),
        .a_o    (mix_a),
        .b_o    (mix_b),
        .zero_o (mix_zero)
    );

    // Next-state decision for a consumed word: zero reject, update, match.
    always_comb begin
        take    = !start_i && word_vld_i && open_q;
        nxt_dec = dec_q;
        nxt_ver = ver_q;
        nxt_a   = acc_a_q;
        nxt_b   = acc_b_q;
        if (take && !dec_q) begin
            if (mix_zero) begin
                nxt_dec = 1'b1;
                nxt_ver = 1'b0;
            end else begin
                nxt_a = mix_a;
                nxt_b = mix_b;
                if (mix_a == TARGET_A && mix_b == TARGET_B) begin
                    nxt_dec = 1'b1;
                    nxt_ver = 1'b1;
                end
            end
        end
    end

    // State registers: clear on reset/start, otherwise follow the decision.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            acc_a_q <= '0;
            acc_b_q <= '0;
            open_q  <= 1'b1;
            dec_q   <= 1'b0;
            ver_q   <= 1'b0;
        end else begin
            acc_a_q <= nxt_a;
            acc_b_q <= nxt_b;
            dec_q   <= nxt_dec;
            ver_q   <= nxt_ver;
            if (take && last_i) begin
                open_q <= 1'b0;
            end
        end
    end

    // Verdict record: one pulse when the last word of an open candidate is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q <= '0;
        end else begin
            fin_q.vld <= take && last_i;
            fin_q.acc <= take && last_i && nxt_dec && nxt_ver;
        end
    end

    assign fin_o = fin_q;

    // R2: a start cycle leaves both accumulators cleared.
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (acc_a_q == '0 && acc_b_q == '0 && !dec_q));

    // R7: idle cycles keep the accumulators and the verdict.
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !word_vld_i) |=>
            ($stable(acc_a_q) && $stable(acc_b_q) && $stable(dec_q) && $stable(ver_q)));

    // R4: an undecided candidate fed a zero word ends up rejected.
    a_r4_zero_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && word_vld_i && open_q && !dec_q && word_i == '0) |=> (dec_q && !ver_q));

    // R5: a latched verdict never changes before the next start.
    a_r5_verdict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q && !start_i) |=> (dec_q && ver_q == $past(ver_q)));

    // R8: a closed candidate produces no further verdict record.
    a_r8_closed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && !start_i) |=> !fin_q.vld);

endmodule

// File: rtl/phc_pipe.sv
// Module: phc_pipe
// Fixed-length register chain that delays verdict records to the output.
// Assumes: DEPTH >= 1; every stage clears on reset.
module phc_pipe
    import phc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_t in_i,
    output verdict_t out_o
);
    verdict_t stage_q [DEPTH];

    // One register per stage; stage 0 takes the input, the rest shift.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= in_i;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= '0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign out_o = stage_q[DEPTH-1];

endmodule

// File: rtl/pair_hash_checker.sv
// Module: pair_hash_checker (top)
// Hashes a candidate one word per clock into two accumulators and reports
// accept/reject two cycles after the candidate's last word.
// Assumes: the upstream sequencer sends start, then the words, with last_i on
// the final word; for a 40-bit candidate the fifth byte sits in the third word
// with its other byte zero.
module pair_hash_checker
    import phc_pkg::*;
#(
    parameter int                 DATA_W   = 16,
    parameter logic [DATA_W-1:0]  TARGET_A = 16'hFEB1,
    parameter logic [DATA_W-1:0]  TARGET_B = 16'h9298
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              word_vld_i,
    input  logic              last_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              res_vld_o,
    output logic              accept_o
);
    // Verdict record leaves the accumulator stage one edge after the last word;
    // this many further stages give the two-cycle output delay.
    localparam int OUT_STAGES = 2;

    verdict_t fin;
    verdict_t res;

    phc_accum #(
        .W        (DATA_W),
        .TARGET_A (TARGET_A),
        .TARGET_B (TARGET_B)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .word_vld_i (word_vld_i),
        .last_i     (last_i),
        .word_i     (word_i),
        .fin_o      (fin)
    );

    phc_pipe #(.DEPTH(OUT_STAGES)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (fin),
        .out_o (res)
    );

    assign res_vld_o = res.vld;
    assign accept_o  = res.vld & res.acc;

    // R6: a result pulse is never longer than one cycle.
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |=> !res_vld_o);

    // R6: the accept bit is quiet outside a result pulse.
    a_r6_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> !accept_o);

    // R6: a finished candidate reaches the outputs exactly two edges later.
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        fin.vld |=> ##1 res_vld_o);

endmodule

// File: tb/sim_pair_hash_checker.sv
// Bench for pair_hash_checker: a vector table of back-to-back candidates,
// then directed tests for reset, start handling, gaps, closed candidates
// and the dropped carry.
module sim_pair_hash_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wvld = 1'b0;
    logic        last = 1'b0;
    logic [15:0] word = '0;
    logic        res0, acc0, res1, acc1;

    always #10 clk = ~clk;   // 50 MHz

    // u0: targets 0303/0501, reached by 0100,0200,0300 and by 0200,0301.
    pair_hash_checker #(.DATA_W(16), .TARGET_A(16'h0303), .TARGET_B(16'h0501)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .word_vld_i(wvld),
        .last_i(last), .word_i(word), .res_vld_o(res0), .accept_o(acc0));

    // u1: targets FFFE/0000, reached after FFFF,0100 only if the carry is dropped.
    pair_hash_checker #(.DATA_W(16), .TARGET_A(16'hFFFE), .TARGET_B(16'h0000)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .word_vld_i(wvld),
        .last_i(last), .word_i(word), .res_vld_o(res1), .accept_o(acc1));

    int    tests = 0;
    int    fails = 0;
    int    ecnt  = 0;
    int    due_q [64];
    bit    exp_q [64];
    string tag_q [64];
    int    head = 0;
    int    tail = 0;
    bit    done = 1'b0;

    // Vectors: {w1, w2, w3, expected accept} for u0, driven back to back (R9).
    localparam logic [48:0] VEC [8] = '{
        {16'h0100, 16'h0200, 16'h0300, 1'b1},  // R3 full recurrence match
        {16'h0200, 16'h0301, 16'h1234, 1'b1},  // R5 early match, later word ignored
        {16'h0200, 16'h0301, 16'h0000, 1'b1},  // R5 zero after match keeps accept
        {16'h0200, 16'h0000, 16'h0301, 1'b0},  // R4 zero rejects before a match
        {16'h0100, 16'h0200, 16'h0301, 1'b0},  // R3 near miss
        {16'h0000, 16'h0000, 16'h0000, 1'b0},  // R4 all zero
        {16'hFFFF, 16'h0100, 16'h0500, 1'b0},  // R3 carry case, miss for u0
        {16'h0100, 16'h0200, 16'h0300, 1'b1}   // R2 state cleared after rejects
    };

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Output monitor, 5 ns after each rising edge: checks due results (R6).
    always begin
        @(posedge clk);
        #5;
        ecnt++;
        if (!done) begin
            if (head < tail && due_q[head] < ecnt) begin
                chk(1'b0, {tag_q[head], " missing result"}, 32'(res0), 32'd1);
                head++;
            end
            if (head < tail && due_q[head] == ecnt) begin
                chk(res0 === 1'b1 && acc0 === exp_q[head], tag_q[head],
                    {30'd0, res0, acc0}, {30'd0, 1'b1, exp_q[head]});
                head++;
            end else if (res0 === 1'b1) begin
                fails++;
                $display("FAIL R6 unexpected result pulse actual=%0h expected=%0h", res0, 1'b0);
            end
        end
    end

    task automatic drive(bit s, bit v, bit l, logic [15:0] w);
        @(negedge clk);
        start = s; wvld = v; last = l; word = w;
    endtask

    // Called right after the last word is driven: result due three samples on.
    task automatic expect_res(bit e, string tag);
        due_q[tail] = ecnt + 3;
        exp_q[tail] = e;
        tag_q[tail] = tag;
        tail++;
    endtask

    task automatic cand(logic [15:0] w1, logic [15:0] w2, logic [15:0] w3, bit e, string tag);
        drive(1'b1, 1'b0, 1'b0, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, w1);
        drive(1'b0, 1'b1, 1'b0, w2);
        drive(1'b0, 1'b1, 1'b1, w3);
        expect_res(e, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 16'h0000);
    endtask

    initial begin
        int d;
        // R1: outputs low while and after reset.
        repeat (3) @(negedge clk);
        chk(res0 === 1'b0 && acc0 === 1'b0, "R1 reset outputs", {res0, acc0}, 2'b00);
        rst_n = 1'b1;
        // R1: reset opens a cleared candidate without a start strobe.
        drive(1'b0, 1'b1, 1'b0, 16'h0100);
        drive(1'b0, 1'b1, 1'b0, 16'h0200);
        drive(1'b0, 1'b1, 1'b1, 16'h0300);
        expect_res(1'b1, "R1 candidate after reset");

        // Vector table, back to back (R3 R4 R5 R9).
        for (int i = 0; i < 8; i++) begin
            cand(VEC[i][48:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0],
                 $sformatf("R9 vector %0d", i));
        end
        idle(4);

        // R2: start cycles alone give no result.
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 1'b0, 1'b0, 16'h0000);
            chk(res0 === 1'b0, "R2 start alone no result", res0, 1'b0);
        end

        // R2: start mid-candidate discards it; only the new one reports.
        drive(1'b1, 1'b0, 1'b0, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 16'h0100);
        drive(1'b0, 1'b1, 1'b0, 16'h0000);
        cand(16'h0100, 16'h0200, 16'h0300, 1'b1, "R2 abort then fresh candidate");

        // R2: a zero word in the start cycle is ignored.
        drive(1'b1, 1'b1, 1'b0, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 16'h0100);
        drive(1'b0, 1'b1, 1'b0, 16'h0200);
        drive(1'b0, 1'b1, 1'b1, 16'h0300);
        expect_res(1'b1, "R2 word in start cycle ignored");

        // R7: idle gaps between words do not change the result.
        drive(1'b1, 1'b0, 1'b0, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 16'h0100);
        drive(1'b0, 1'b0, 1'b0, 16'h0000);
        drive(1'b0, 1'b0, 1'b1, 16'h0000);
        drive(1'b0, 1'b1, 1'b0, 16'h0200);
        drive(1'b0, 1'b0, 1'b0, 16'hFFFF);
        drive(1'b0, 1'b1, 1'b1, 16'h0300);
        expect_res(1'b1, "R7 gaps between words");
        idle(4);

        // R8: words after the last word give no result.
        drive(1'b0, 1'b1, 1'b0, 16'h0000);
        drive(1'b0, 1'b1, 1'b1, 16'h0300);
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 1'b0, 1'b0, 16'h0000);
            chk(res0 === 1'b0, "R8 closed candidate silent", res0, 1'b0);
        end
        // R8: the ignored words did not disturb the next candidate.
        cand(16'h0200, 16'h0301, 16'h0777, 1'b1, "R8 next candidate after ignored words");
        idle(4);

        // R3: carry out of bit 15 dropped; u1 accepts, u0 rejects.
        cand(16'hFFFF, 16'h0100, 16'h0500, 1'b0, "R3 carry case on u0");
        d = ecnt + 3;
        while (ecnt < d) @(negedge clk);
        chk(res1 === 1'b1 && acc1 === 1'b1, "R3 dropped carry accept", {res1, acc1}, 2'b11);
        @(negedge clk);
        chk(res1 === 1'b0 && acc1 === 1'b0, "R6 pulse one cycle wide", {res1, acc1}, 2'b00);

        idle(6);
        chk(head == tail, "R6 every result seen", head, tail);
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

endmodule